// File: doc/BRIEF.md
# Framebuffer Pixel Format Unpacker

This block sits between a framebuffer fetch engine and a palette or colour stage. It accepts 32-bit words on a valid/ready stream and emits one pixel per handshake on a second valid/ready stream. Each pixel is either an 8-bit palette index, zero-extended into the 24-bit pixel bus with the index flag raised, or a direct 24-bit colour `{R[7:0], G[7:0], B[7:0]}`. Static configuration inputs select the pixel layout: the depth code, byte and sub-byte ordering, red/blue channel order, and a 2-bit board mux code that can reinterpret the plain 16-bit mode. The block also reports, combinationally, how many framebuffer bytes one line of the configured width occupies. Configuration may only change while no word is held, which means between lines.

Control is a two-state machine. `ST_WAIT_WORD` holds no data. It raises `in_ready_o` and takes the transition *fetch* to `ST_EMIT` when a word is accepted. `ST_EMIT` presents one pixel of the held word. On each output handshake it takes one of three transitions. *advance* moves to the next pixel of the same word. *reload* applies when the word is used up, or the line ends, and a new word is offered in that same cycle: the new word is taken and the state stays `ST_EMIT`, so no cycle is lost. *drain* applies in the same case when no new word is offered, and returns to `ST_WAIT_WORD`. A column counter counts the pixels of the line. When it reaches the column count, the rest of the held word is dropped and the next word starts a new line.

Top module: `pxu_unpacker`

## Requirements
- R1: `line_bytes_o` equals cols/8, cols/4, cols/2 and cols for depth codes 0, 1, 2 and 3 (1, 2, 4 and 8 bpp). It equals cols*2 for codes 4, 6 and 7 (16-bit, 16-bit 5:6:5 and 12-bit 4:4:4). It equals cols*4 for code 5 (32-bit).
- R2: Codes 0 to 3 emit palette indices with `out_is_index_o`=1 and `out_pix_o[23:8]`=0. With both ordering bits clear, the first pixel of a word comes from bits [b-1:0], and later pixels come from successively higher bit groups of width b.
- R3: With `be_pix_i`=1 and `be_byte_i`=0, bytes are still consumed from bit 0 upward, but sub-byte pixels inside each byte are taken from bit 7 downward. At 8 bpp and above this bit has no effect.
- R4: With `be_byte_i`=1, pixel k of a word is taken from bits [32-(k+1)*b +: b], for every depth. `be_byte_i` overrides `be_pix_i` when both are set.
- R5: With mux variant enabled, code 4 is decoded from `mux_i`. Value 1 selects 1:5:5:5: c0=[4:0], c1=[9:5], c2=[14:10], and bit 15 is ignored. Value 3 selects 5:6:5 as if `bgr_i`=1. Values 0 and 2 select 5:6:5 and follow `bgr_i`. The 5:6:5 layout is c0=[4:0], c1=[10:5], c2=[15:11].
- R6: With `bgr_i`=1, R=c0, G=c1 and B=c2. With `bgr_i`=0, red and blue are exchanged (R=c2, B=c0). In 32-bit mode c0=[7:0], c1=[15:8] and c2=[23:16], and bits [31:24] are ignored.
- R7: Narrow channels widen to 8 bits by repeating their top bits below them: 5-bit v becomes {v,v[4:2]}, 6-bit v becomes {v,v[5:4]}, and 4-bit v becomes {v,v}. Code 7 uses c0=[3:0], c1=[7:4] and c2=[11:8].
- R8: After `cols_i` pixels, the rest of the held word is discarded. The next word supplies the first pixel of the next line.
- R9: A presented pixel and its flag hold steady while `out_ready_o` is low, and no word is accepted during such a stall. Words offered without gaps yield one pixel per cycle across word boundaries.
- R10: After reset, `out_valid_o`=0 and `in_ready_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Depth code 0..7 |
| bgr_i | input | 1 | Channel order: 1 = c0 is red |
| be_byte_i | input | 1 | Whole-word reversed pixel order |
| be_pix_i | input | 1 | Sub-byte pixels from the top of each byte |
| mux_i | input | 2 | Board mux code reinterpreting code 4 |
| cols_i | input | COL_W | Pixels per line, at least 1 |
| line_bytes_o | output | COL_W+2 | Bytes per framebuffer line |
| in_valid_i | input | 1 | Word offered |
| in_ready_o | output | 1 | Word accepted when high with valid |
| in_data_i | input | 32 | Framebuffer word |
| out_valid_o | output | 1 | Pixel presented |
| out_ready_i | input | 1 | Pixel consumer ready |
| out_pix_o | output | 24 | Index (zero-extended) or {R,G,B} |
| out_is_index_o | output | 1 | Pixel is a palette index |

## Verification
A wrong pixel position register shows up on the very next handshake, as a pixel taken from the wrong bit group. A fault in the column counter shows up at the first line end: pixels from the padding tail appear, or the next line is shifted by one or more pixels. A wrong state or a wrong ready decision shows up within one cycle, either as a bubble between words, a word taken during a stall, or a pixel that changes while held. The directed tests therefore compare every emitted pixel in order, with and without output stalls, across word and line boundaries.

// File: rtl/pxu_pkg.sv
`timescale 1ns/1ps
package pxu_pkg;
    localparam int WORD_W = 32;
    localparam int PIX_W  = 24;
    localparam int POS_W  = 5;

    typedef enum logic [2:0] {
        FMT_IDX,
        FMT_5551,
        FMT_565,
        FMT_444,
        FMT_888
    } pxu_fmt_e;

    function automatic logic [7:0] widen4(input logic [3:0] v);
        return {v, v};
    endfunction

    function automatic logic [7:0] widen5(input logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    function automatic logic [7:0] widen6(input logic [5:0] v);
        return {v, v[5:4]};
    endfunction
endpackage

// File: rtl/pxu_cfg_decode.sv
`timescale 1ns/1ps
module pxu_cfg_decode
    import pxu_pkg::*;
#(
    parameter int COL_W   = 12,
    parameter bit HAS_MUX = 1'b1
) (
    input  logic [2:0]       mode_i,
    input  logic [1:0]       mux_i,
    input  logic             bgr_i,
    input  logic [COL_W-1:0] cols_i,
    output pxu_fmt_e         fmt_o,
    output logic [2:0]       log2b_o,
    output logic             is_index_o,
    output logic             bgr_eff_o,
    output logic [COL_W+1:0] line_bytes_o
);
    localparam int LB_W = COL_W + 2;

    pxu_fmt_e m4_fmt;
    logic     m4_bgr;

    generate
        if (HAS_MUX) begin : g_mux
            always_comb begin
                case (mux_i)
                    2'd1: begin m4_fmt = FMT_5551; m4_bgr = bgr_i; end
                    2'd3: begin m4_fmt = FMT_565;  m4_bgr = 1'b1;  end
                    default: begin m4_fmt = FMT_565; m4_bgr = bgr_i; end
                endcase
            end
        end else begin : g_plain
            assign m4_fmt = FMT_5551;
            assign m4_bgr = bgr_i;
        end
    endgenerate

    logic [LB_W-1:0] cols_x;
    assign cols_x = {2'b00, cols_i};

    always_comb begin
        fmt_o        = FMT_IDX;
        log2b_o      = 3'd3;
        is_index_o   = 1'b0;
        bgr_eff_o    = bgr_i;
        line_bytes_o = cols_x;
        unique case (mode_i)
            3'd0, 3'd1, 3'd2, 3'd3: begin
                fmt_o        = FMT_IDX;
                log2b_o      = mode_i;
                is_index_o   = 1'b1;
                line_bytes_o = cols_x >> (3'd3 - mode_i);
            end
            3'd4: begin
                fmt_o        = m4_fmt;
                bgr_eff_o    = m4_bgr;
                log2b_o      = 3'd4;
                line_bytes_o = cols_x << 1;
            end
            3'd5: begin
                fmt_o        = FMT_888;
                log2b_o      = 3'd5;
                line_bytes_o = cols_x << 2;
            end
            3'd6: begin
                fmt_o        = FMT_565;
                log2b_o      = 3'd4;
                line_bytes_o = cols_x << 1;
            end
            3'd7: begin
                fmt_o        = FMT_444;
                log2b_o      = 3'd4;
                line_bytes_o = cols_x << 1;
            end
        endcase
    end
endmodule

// File: rtl/pxu_extract.sv
`timescale 1ns/1ps
module pxu_extract
    import pxu_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [POS_W-1:0]  pos_i,
    input  logic [2:0]        log2b_i,
    input  logic              be_byte_i,
    input  logic              be_pix_i,
    output logic [WORD_W-1:0] raw_o
);
    localparam int OFF_W = 11;

    logic [OFF_W-1:0] k_x, off_le, off_be, off_bp, off_sel;
    logic [OFF_W-1:0] byte_j, sub_s;
    logic [2:0]       per_byte_log;
    logic [WORD_W-1:0] mask;

    always_comb begin
        k_x          = {{(OFF_W-POS_W){1'b0}}, pos_i};
        per_byte_log = 3'd3 - log2b_i;
        off_le       = k_x << log2b_i;
        off_be       = OFF_W'(32) - ((k_x + OFF_W'(1)) << log2b_i);
        byte_j       = k_x >> per_byte_log;
        sub_s        = k_x & ((OFF_W'(1) << per_byte_log) - OFF_W'(1));
        off_bp       = (byte_j << 3) + OFF_W'(8) - ((sub_s + OFF_W'(1)) << log2b_i);
        if (be_byte_i)
            off_sel = off_be;
        else if (be_pix_i && (log2b_i < 3'd3))
            off_sel = off_bp;
        else
            off_sel = off_le;
        if (log2b_i >= 3'd5)
            mask = '1;
        else
            mask = (WORD_W'(1) << (6'd1 << log2b_i)) - WORD_W'(1);
        raw_o = (word_i >> off_sel[4:0]) & mask;
    end
endmodule

// File: rtl/pxu_color.sv
`timescale 1ns/1ps
module pxu_color
    import pxu_pkg::*;
(
    input  logic [WORD_W-1:0] raw_i,
    input  pxu_fmt_e          fmt_i,
    input  logic              bgr_i,
    output logic [PIX_W-1:0]  pix_o
);
    logic [7:0] c0, c1, c2;

    always_comb begin
        c0 = 8'h00;
        c1 = 8'h00;
        c2 = 8'h00;
        unique case (fmt_i)
            FMT_IDX: c0 = raw_i[7:0];
            FMT_5551: begin
                c0 = widen5(raw_i[4:0]);
                c1 = widen5(raw_i[9:5]);
                c2 = widen5(raw_i[14:10]);
            end
            FMT_565: begin
                c0 = widen5(raw_i[4:0]);
                c1 = widen6(raw_i[10:5]);
                c2 = widen5(raw_i[15:11]);
            end
            FMT_444: begin
                c0 = widen4(raw_i[3:0]);
                c1 = widen4(raw_i[7:4]);
                c2 = widen4(raw_i[11:8]);
            end
            FMT_888: begin
                c0 = raw_i[7:0];
                c1 = raw_i[15:8];
                c2 = raw_i[23:16];
            end
            default: c0 = 8'h00;
        endcase
        if (fmt_i == FMT_IDX)
            pix_o = {16'h0000, c0};
        else if (bgr_i)
            pix_o = {c0, c1, c2};
        else
            pix_o = {c2, c1, c0};
    end
endmodule

// File: rtl/pxu_unpacker.sv
`timescale 1ns/1ps
module pxu_unpacker
    import pxu_pkg::*;
#(
    parameter int COL_W   = 12,
    parameter bit HAS_MUX = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_i,
    input  logic             bgr_i,
    input  logic             be_byte_i,
    input  logic             be_pix_i,
    input  logic [1:0]       mux_i,
    input  logic [COL_W-1:0] cols_i,
    output logic [COL_W+1:0] line_bytes_o,
    input  logic             in_valid_i,
    output logic             in_ready_o,
    input  logic [31:0]      in_data_i,
    output logic             out_valid_o,
    input  logic             out_ready_i,
    output logic [23:0]      out_pix_o,
    output logic             out_is_index_o
);
    typedef enum logic {ST_WAIT_WORD, ST_EMIT} pxu_state_e;

    pxu_state_e        state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic [POS_W-1:0]  pos_q, last_pos;
    logic [COL_W-1:0]  col_q;

    pxu_fmt_e   fmt;
    logic [2:0] log2b;
    logic       is_index, bgr_eff;
    logic [WORD_W-1:0] raw;

    logic take, word_done, line_end, accept;

    pxu_cfg_decode #(.COL_W(COL_W), .HAS_MUX(HAS_MUX)) i_decode (
        .mode_i      (mode_i),
        .mux_i       (mux_i),
        .bgr_i       (bgr_i),
        .cols_i      (cols_i),
        .fmt_o       (fmt),
        .log2b_o     (log2b),
        .is_index_o  (is_index),
        .bgr_eff_o   (bgr_eff),
        .line_bytes_o(line_bytes_o)
    );

    pxu_extract i_extract (
        .word_i   (word_q),
        .pos_i    (pos_q),
        .log2b_i  (log2b),
        .be_byte_i(be_byte_i),
        .be_pix_i (be_pix_i),
        .raw_o    (raw)
    );

    pxu_color i_color (
        .raw_i (raw),
        .fmt_i (fmt),
        .bgr_i (bgr_eff),
        .pix_o (out_pix_o)
    );

    // Outputs and transition conditions
    always_comb begin
        last_pos       = POS_W'(5'd31 >> log2b);
        out_valid_o    = (state_q == ST_EMIT);
        out_is_index_o = is_index;
        take           = out_valid_o && out_ready_i;
        line_end       = (col_q == cols_i - COL_W'(1));
        word_done      = take && ((pos_q == last_pos) || line_end);
        in_ready_o     = (state_q == ST_WAIT_WORD) || word_done;
        accept         = in_valid_i && in_ready_o;
    end

    // Next state: fetch, advance, reload, drain
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_WORD: if (in_valid_i) state_d = ST_EMIT;
            ST_EMIT:      if (word_done && !in_valid_i) state_d = ST_WAIT_WORD;
            default:      state_d = ST_WAIT_WORD;
        endcase
    end

    // State register and held word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_WORD;
            word_q  <= '0;
            pos_q   <= '0;
            col_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                word_q <= in_data_i;
                pos_q  <= '0;
            end else if (take) begin
                pos_q <= pos_q + POS_W'(1);
            end
            if (take)
                col_q <= line_end ? '0 : col_q + COL_W'(1);
        end
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_pix_o) && $stable(out_is_index_o));

    p_no_take_in_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |-> !in_ready_o);

    p_accept_fills_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i && in_ready_o |=> out_valid_o);

    p_index_zero_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && (mode_i <= 3'd3) |-> out_is_index_o && (out_pix_o[23:8] == 16'h0));

    p_col_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        col_q < cols_i);

    p_idle_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> in_ready_o);
endmodule

// File: tb/test_pxu_unpacker.sv
`timescale 1ns/1ps
module test_pxu_unpacker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'd3;
    logic        bgr = 1'b1, be_byte = 1'b0, be_pix = 1'b0;
    logic [1:0]  mux = 2'd1;
    logic [11:0] cols = 12'd4;
    logic [13:0] line_bytes;
    logic        in_valid = 1'b0, in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid, out_ready = 1'b1, out_is_index;
    logic [23:0] out_pix;

    int checks = 0;
    int errors = 0;

    logic [31:0] wq [8];
    logic [23:0] ep [16];
    logic        ei [16];
    int          first_cyc, last_cyc, hold_bad;

    always #4 clk = ~clk;

    pxu_unpacker i_pxu_unpacker (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .bgr_i(bgr), .be_byte_i(be_byte),
        .be_pix_i(be_pix), .mux_i(mux), .cols_i(cols), .line_bytes_o(line_bytes),
        .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
        .out_valid_o(out_valid), .out_ready_i(out_ready), .out_pix_o(out_pix),
        .out_is_index_o(out_is_index)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] m, input logic b, input logic bb, input logic bp,
                       input logic [1:0] mx, input logic [11:0] c);
        @(negedge clk);
        mode = m; bgr = b; be_byte = bb; be_pix = bp; mux = mx; cols = c;
    endtask

    task automatic produce(input int nw);
        for (int i = 0; i < nw; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = wq[i];
            #3;
            while (!in_ready) begin
                @(negedge clk);
                #3;
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic consume(input int np, input bit stall, input string tag);
        int got = 0;
        int cyc = 0;
        bit held = 1'b0;
        logic [23:0] hpix;
        hold_bad = 0;
        first_cyc = -1;
        while (got < np) begin
            @(negedge clk);
            out_ready = !(stall && (cyc % 3 == 1));
            #3;
            if (held && (!out_valid || out_pix != hpix)) hold_bad++;
            held = 1'b0;
            if (out_valid && out_ready) begin
                chk((out_pix == ep[got]) && (out_is_index == ei[got]), tag,
                    {7'd0, out_is_index, out_pix}, {7'd0, ei[got], ep[got]});
                if (first_cyc < 0) first_cyc = cyc;
                last_cyc = cyc;
                got++;
            end else if (out_valid) begin
                held = 1'b1;
                hpix = out_pix;
            end
            cyc++;
        end
        @(negedge clk);
        out_ready = 1'b1;
    endtask

    task automatic run(input int nw, input int np, input bit stall, input string tag);
        fork
            produce(nw);
            consume(np, stall, tag);
        join
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        #1;
        chk(out_valid == 1'b0, "R10 out_valid after reset", {31'd0, out_valid}, 32'd0);
        chk(in_ready == 1'b1, "R10 in_ready after reset", {31'd0, in_ready}, 32'd1);
    endtask

    task automatic t_line_bytes;
        logic [13:0] exp [8];
        exp = '{14'd12, 14'd25, 14'd50, 14'd100, 14'd200, 14'd400, 14'd200, 14'd200};
        for (int m = 0; m < 8; m++) begin
            cfg(3'(m), 1'b1, 1'b0, 1'b0, 2'd1, 12'd100);
            #1;
            chk(line_bytes == exp[m], $sformatf("R1 line bytes mode %0d", m), {18'd0, line_bytes}, {18'd0, exp[m]});
        end
    endtask

    task automatic t_indexed_le;
        cfg(3'd3, 1'b1, 1'b0, 1'b0, 2'd1, 12'd4);
        wq[0] = 32'h44332211;
        ep[0] = 24'h11; ep[1] = 24'h22; ep[2] = 24'h33; ep[3] = 24'h44;
        for (int i = 0; i < 4; i++) ei[i] = 1'b1;
        run(1, 4, 1'b0, "R2 8bpp little-endian");
        cfg(3'd2, 1'b1, 1'b0, 1'b0, 2'd1, 12'd8);
        wq[0] = 32'h87654321;
        for (int i = 0; i < 8; i++) begin ep[i] = 24'(i + 1); ei[i] = 1'b1; end
        run(1, 8, 1'b1, "R2 4bpp little-endian");
        cfg(3'd0, 1'b1, 1'b0, 1'b0, 2'd1, 12'd8);
        wq[0] = 32'hFFFFFFA5;
        ep[0] = 1; ep[1] = 0; ep[2] = 1; ep[3] = 0; ep[4] = 0; ep[5] = 1; ep[6] = 0; ep[7] = 1;
        run(1, 8, 1'b0, "R2 1bpp little-endian");
    endtask

    task automatic t_be_pix;
        cfg(3'd1, 1'b1, 1'b0, 1'b1, 2'd1, 12'd4);
        wq[0] = 32'h0000001B;
        for (int i = 0; i < 4; i++) begin ep[i] = 24'(i); ei[i] = 1'b1; end
        run(1, 4, 1'b0, "R3 2bpp sub-byte from msb");
        cfg(3'd3, 1'b1, 1'b0, 1'b1, 2'd1, 12'd4);
        wq[0] = 32'h44332211;
        ep[0] = 24'h11; ep[1] = 24'h22; ep[2] = 24'h33; ep[3] = 24'h44;
        run(1, 4, 1'b0, "R3 8bpp unaffected by pixel order bit");
    endtask

    task automatic t_be_byte;
        cfg(3'd3, 1'b1, 1'b1, 1'b0, 2'd1, 12'd4);
        wq[0] = 32'h44332211;
        ep[0] = 24'h44; ep[1] = 24'h33; ep[2] = 24'h22; ep[3] = 24'h11;
        for (int i = 0; i < 4; i++) ei[i] = 1'b1;
        run(1, 4, 1'b0, "R4 8bpp reversed");
        cfg(3'd2, 1'b1, 1'b1, 1'b1, 2'd1, 12'd8);
        wq[0] = 32'h87654321;
        for (int i = 0; i < 8; i++) begin ep[i] = 24'(8 - i); ei[i] = 1'b1; end
        run(1, 8, 1'b0, "R4 byte order wins over pixel order");
        cfg(3'd6, 1'b1, 1'b1, 1'b0, 2'd1, 12'd2);
        wq[0] = 32'h07E0F800;
        ep[0] = 24'h00FF00; ep[1] = 24'h0000FF; ei[0] = 1'b0; ei[1] = 1'b0;
        run(1, 2, 1'b0, "R4 16-bit reversed halves");
    endtask

    task automatic t_mux;
        wq[0] = 32'h0000F800;
        ei[0] = 1'b0; ei[1] = 1'b0; ep[1] = 24'h000000;
        cfg(3'd4, 1'b1, 1'b0, 1'b0, 2'd1, 12'd2);
        ep[0] = 24'h0000F7;
        run(1, 2, 1'b0, "R5 mux 1 gives 1:5:5:5");
        cfg(3'd4, 1'b0, 1'b0, 1'b0, 2'd3, 12'd2);
        ep[0] = 24'h0000FF;
        run(1, 2, 1'b0, "R5 mux 3 forces channel order");
        cfg(3'd4, 1'b0, 1'b0, 1'b0, 2'd0, 12'd2);
        ep[0] = 24'hFF0000;
        run(1, 2, 1'b0, "R5 mux 0 follows order bit");
        cfg(3'd4, 1'b1, 1'b0, 1'b0, 2'd2, 12'd2);
        ep[0] = 24'h0000FF;
        run(1, 2, 1'b0, "R5 mux 2 follows order bit");
    endtask

    task automatic t_bgr;
        wq[0] = 32'hEE112233;
        ei[0] = 1'b0;
        cfg(3'd5, 1'b1, 1'b0, 1'b0, 2'd1, 12'd1);
        ep[0] = 24'h332211;
        run(1, 1, 1'b0, "R6 32-bit order bit set");
        cfg(3'd5, 1'b0, 1'b0, 1'b0, 2'd1, 12'd1);
        ep[0] = 24'h112233;
        run(1, 1, 1'b0, "R6 32-bit order bit clear");
    endtask

    task automatic t_expand;
        cfg(3'd6, 1'b1, 1'b0, 1'b0, 2'd1, 12'd2);
        wq[0] = 32'h082007E0;
        ep[0] = 24'h00FF00; ep[1] = 24'h000408; ei[0] = 1'b0; ei[1] = 1'b0;
        run(1, 2, 1'b0, "R7 5:6:5 widening");
        cfg(3'd7, 1'b1, 1'b0, 1'b0, 2'd1, 12'd1);
        wq[0] = 32'h1234FA5F;
        ep[0] = 24'hFF55AA;
        run(1, 1, 1'b0, "R7 4:4:4 widening");
    endtask

    task automatic t_line_wrap;
        cfg(3'd3, 1'b1, 1'b0, 1'b0, 2'd1, 12'd6);
        wq[0] = 32'h44332211; wq[1] = 32'h88776655;
        wq[2] = 32'hCCBBAA99; wq[3] = 32'h00FFEEDD;
        ep[0] = 24'h11; ep[1] = 24'h22; ep[2] = 24'h33; ep[3] = 24'h44;
        ep[4] = 24'h55; ep[5] = 24'h66; ep[6] = 24'h99; ep[7] = 24'hAA;
        ep[8] = 24'hBB; ep[9] = 24'hCC; ep[10] = 24'hDD; ep[11] = 24'hEE;
        for (int i = 0; i < 12; i++) ei[i] = 1'b1;
        run(4, 12, 1'b1, "R8 padding dropped at line end");
        chk(hold_bad == 0, "R9 pixel held during stall", 32'(hold_bad), 32'd0);
    endtask

    task automatic t_back_to_back;
        cfg(3'd3, 1'b1, 1'b0, 1'b0, 2'd1, 12'd8);
        wq[0] = 32'h04030201; wq[1] = 32'h08070605;
        for (int i = 0; i < 8; i++) begin ep[i] = 24'(i + 1); ei[i] = 1'b1; end
        run(2, 8, 1'b0, "R9 gapless stream");
        chk(last_cyc - first_cyc == 7, "R9 one pixel per cycle", 32'(last_cyc - first_cyc), 32'd7);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_line_bytes();
        t_indexed_le();
        t_be_pix();
        t_be_byte();
        t_mux();
        t_bgr();
        t_expand();
        t_line_wrap();
        t_back_to_back();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule